// File: doc/BRIEF.md
# Multi-Profile Clock-Enable Tree

The block turns a 32 MHz master clock into single-cycle enable strobes for the slower peripheral domains of a home-computer-style system. It also turns an optional secondary oscillator into enable strobes in that oscillator's own clock domain. Loads run on the master clock and qualify their registers with a strobe, so the design needs no extra clocks, PLLs or clock muxes.

A 3-bit profile code selects one of five derivation schemes. The schemes differ in which divider taps feed the bus, CPU and blitter enables, and in whether the 2 MHz strobe comes from the master counter or from the secondary oscillator. The profile code is sampled only on a synchronous soft reset. That soft reset also restarts the master counter, so every master-domain strobe has a known phase afterwards.

All master-domain strobes are decoded from one free-running 6-bit counter. Slower strobes therefore always coincide with faster ones.

Top module: `clken_tree`

## Requirements
- R1: While `rst_ni` is low, every output is 0. After `rst_ni` rises, the block acts as profile 0 until the first soft reset, whatever `profile_i` holds.
- R2: `profile_i` is sampled only in a cycle with `srst_i` high. Changes on `profile_i` at any other time have no effect on any output.
- R3: In every profile, `en16_o` pulses once every 2 master cycles, `en8_o` once every 4, and `en4_o` once every 8.
- R4: `en2_o` pulses once every 16 master cycles in profiles 0, 3 and 4. It is held at 0 in profiles 1 and 2, where the 2 MHz strobe comes from the secondary oscillator.
- R5: In every profile, `en500k_o` pulses once every 64 master cycles.
- R6: `bus_en_o` pulses once every 4 master cycles in profiles 0, 1 and 2, and once every 2 master cycles in profiles 3 and 4.
- R7: `cpu_en_o` pulses once every 4 master cycles in profiles 0 and 1, and once every 2 in profiles 2 and 4. It is high on every cycle in profile 3.
- R8: `blit_en_o` pulses once every 4 master cycles in profiles 0, 1 and 2, and once every 2 in profile 4. It is held at 0 in profile 3.
- R9: In the oscillator domain:
  - In profile 1, `osc_rate_en_o` is high on every oscillator cycle and `osc_en2_o` pulses once every 4 oscillator cycles.
  - In profile 2, `osc_rate_en_o` pulses once every 2 oscillator cycles and `osc_en2_o` once every 8.
  - In profiles 0, 3 and 4, both outputs stay at 0.
- R10: Profile codes 5, 6 and 7 behave exactly like profile 0.
- R11: In the cycle after `srst_i` is high, all master-domain strobes are 0, even if a strobe was due. Counting that cycle as cycle 0, the first `en16_o` arrives in cycle 1, the first `en8_o` in cycle 3 and the first `en500k_o` in cycle 63.
- R12: Whenever `en500k_o` is high, `en16_o`, `en8_o` and `en4_o` are high too. The master strobes are phase-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32 MHz master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_clk_i | input | 1 | Secondary oscillator clock |
| srst_i | input | 1 | Synchronous soft reset; loads the profile and restarts the counter |
| profile_i | input | 3 | Profile code, sampled on `srst_i` |
| en16_o | output | 1 | 16 MHz enable |
| en8_o | output | 1 | 8 MHz enable |
| en4_o | output | 1 | 4 MHz enable |
| en2_o | output | 1 | 2 MHz enable from the master counter |
| en500k_o | output | 1 | 500 kHz enable |
| bus_en_o | output | 1 | Bus-rate enable |
| cpu_en_o | output | 1 | CPU-rate enable |
| blit_en_o | output | 1 | Blitter-rate enable |
| osc_rate_en_o | output | 1 | Secondary 8 MHz rate enable, for audio DMA and disk controller (oscillator domain) |
| osc_en2_o | output | 1 | 2 MHz enable from the secondary oscillator (oscillator domain) |

## Verification
The soft reset and a due strobe can fall on the same master edge.

The bench waits for an `en500k_o` pulse and then counts to the cycle just before the next one is due. It raises `srst_i` so that it lands on that very edge. It then judges three things:
- the 500 kHz strobe must be absent in that cycle;
- the first `en16_o` must follow one cycle later;
- the first `en500k_o` must follow 63 cycles later.

For each profile, the counting windows span a whole multiple of every period, so the pulse counts do not depend on phase.

// File: rtl/clken_tree_pkg.sv
package clken_tree_pkg;
  localparam int MCNT_W = 6;
  localparam int OCNT_W = 3;
  localparam int LG_W   = $clog2(MCNT_W + 1);
  localparam int NUM_EN = 8;

  localparam int EN_16   = 0;
  localparam int EN_8    = 1;
  localparam int EN_4    = 2;
  localparam int EN_2    = 3;
  localparam int EN_500K = 4;
  localparam int EN_BUS  = 5;
  localparam int EN_CPU  = 6;
  localparam int EN_BLIT = 7;

  typedef enum logic [2:0] {
    PR_BASE  = 3'd0,
    PR_OSC8  = 3'd1,
    PR_OSC16 = 3'd2,
    PR_WIDE  = 3'd3,
    PR_FAST  = 3'd4
  } prof_e;

  typedef struct packed {
    logic            on;
    logic [LG_W-1:0] lg;
  } tap_t;

  function automatic prof_e prof_decode(logic [2:0] code);
    case (code)
      3'd1:    return PR_OSC8;
      3'd2:    return PR_OSC16;
      3'd3:    return PR_WIDE;
      3'd4:    return PR_FAST;
      default: return PR_BASE;
    endcase
  endfunction

  function automatic tap_t mk_tap(logic on, int lg);
    tap_t t;
    t.on = on;
    t.lg = LG_W'(lg);
    return t;
  endfunction

  // lg = log2 of the strobe period in master cycles
  function automatic tap_t tap_cfg(prof_e p, int idx);
    case (idx)
      EN_16:   return mk_tap(1'b1, 1);
      EN_8:    return mk_tap(1'b1, 2);
      EN_4:    return mk_tap(1'b1, 3);
      EN_2:    return mk_tap(!(p == PR_OSC8 || p == PR_OSC16), 4);
      EN_500K: return mk_tap(1'b1, MCNT_W);
      EN_BUS:  return mk_tap(1'b1, (p == PR_WIDE || p == PR_FAST) ? 1 : 2);
      EN_CPU: begin
        case (p)
          PR_WIDE:           return mk_tap(1'b1, 0);
          PR_OSC16, PR_FAST: return mk_tap(1'b1, 1);
          default:           return mk_tap(1'b1, 2);
        endcase
      end
      EN_BLIT: begin
        case (p)
          PR_WIDE: return mk_tap(1'b0, 0);
          PR_FAST: return mk_tap(1'b1, 1);
          default: return mk_tap(1'b1, 2);
        endcase
      end
      default: return mk_tap(1'b0, 0);
    endcase
  endfunction
endpackage

// File: rtl/ct_tap.sv
module ct_tap
  import clken_tree_pkg::*;
(
  input  logic [MCNT_W-1:0] cnt_i,
  input  tap_t              cfg_i,
  output logic              hit_o
);
  logic [MCNT_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < MCNT_W; b++) begin
      if (b < int'(cfg_i.lg)) mask[b] = 1'b1;
    end
    hit_o = cfg_i.on && ((cnt_i & mask) == mask);
  end
endmodule

// File: rtl/ct_profile.sv
module ct_profile
  import clken_tree_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       srst_i,
  input  logic [2:0] profile_i,
  output prof_e      prof_o
);
  prof_e prof_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prof_q <= PR_BASE;
    else if (srst_i) prof_q <= prof_decode(profile_i);
  end

  assign prof_o = prof_q;

  AST_PROF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srst_i |=> $stable(prof_q)); // R2
endmodule

// File: rtl/ct_mdiv.sv
module ct_mdiv
  import clken_tree_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  prof_e             prof_i,
  output logic [NUM_EN-1:0] en_o
);
  logic [MCNT_W-1:0] cnt_q, cnt_d;
  logic [NUM_EN-1:0] hit, en_q;

  assign cnt_d = srst_i ? '0 : cnt_q + 1'b1;

  for (genvar g = 0; g < NUM_EN; g++) begin : g_tap
    tap_t cfg;
    always_comb cfg = tap_cfg(prof_i, g);
    ct_tap u_tap (.cnt_i(cnt_d), .cfg_i(cfg), .hit_o(hit[g]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= srst_i ? '0 : hit;
    end
  end

  assign en_o = en_q;

  AST_SRST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (cnt_q == '0) && (en_q == '0)); // R11
  AST_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q[EN_500K] |-> (en_q[EN_16] && en_q[EN_8] && en_q[EN_4])); // R12
  AST_EN8_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q[EN_8] |=> !en_q[EN_8]); // R3
  AST_NO_BLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prof_i == PR_WIDE) |-> !en_q[EN_BLIT]); // R8
  AST_EN2_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prof_i == PR_OSC8 || prof_i == PR_OSC16) |-> !en_q[EN_2]); // R4
endmodule

// File: rtl/ct_odiv.sv
module ct_odiv
  import clken_tree_pkg::*;
(
  input  logic  osc_clk_i,
  input  logic  rst_ni,
  input  prof_e prof_i,
  output logic  rate_en_o,
  output logic  en2_o
);
  logic [1:0]        rst_sync_q;
  logic              orst_n;
  logic [2:0]        prof_s1_q, prof_s2_q;
  prof_e             oprof;
  logic [OCNT_W-1:0] cnt_q, cnt_d;
  logic              rate_q, en2_q;

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign orst_n = rst_sync_q[1];

  // profile is quasi-static between soft resets
  always_ff @(posedge osc_clk_i or negedge orst_n) begin
    if (!orst_n) begin
      prof_s1_q <= '0;
      prof_s2_q <= '0;
    end else begin
      prof_s1_q <= prof_i;
      prof_s2_q <= prof_s1_q;
    end
  end
  assign oprof = prof_decode(prof_s2_q);

  assign cnt_d = cnt_q + 1'b1;

  always_ff @(posedge osc_clk_i or negedge orst_n) begin
    if (!orst_n) begin
      cnt_q  <= '0;
      rate_q <= 1'b0;
      en2_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      case (oprof)
        PR_OSC8: begin
          rate_q <= 1'b1;
          en2_q  <= &cnt_d[1:0];
        end
        PR_OSC16: begin
          rate_q <= cnt_d[0];
          en2_q  <= &cnt_d[2:0];
        end
        default: begin
          rate_q <= 1'b0;
          en2_q  <= 1'b0;
        end
      endcase
    end
  end

  assign rate_en_o = rate_q;
  assign en2_o     = en2_q;

  AST_OSC_NEST: assert property (@(posedge osc_clk_i) disable iff (!orst_n)
    en2_q |-> rate_q); // R9
  AST_OSC_EN2_GAP: assert property (@(posedge osc_clk_i) disable iff (!orst_n)
    en2_q |=> !en2_q); // R9
endmodule

// File: rtl/clken_tree.sv
module clken_tree
  import clken_tree_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_clk_i,
  input  logic       srst_i,
  input  logic [2:0] profile_i,
  output logic       en16_o,
  output logic       en8_o,
  output logic       en4_o,
  output logic       en2_o,
  output logic       en500k_o,
  output logic       bus_en_o,
  output logic       cpu_en_o,
  output logic       blit_en_o,
  output logic       osc_rate_en_o,
  output logic       osc_en2_o
);
  prof_e             prof;
  logic [NUM_EN-1:0] en;

  ct_profile u_prof (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i),
    .profile_i(profile_i), .prof_o(prof)
  );

  ct_mdiv u_mdiv (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_i(srst_i),
    .prof_i(prof), .en_o(en)
  );

  ct_odiv u_odiv (
    .osc_clk_i(osc_clk_i), .rst_ni(rst_ni), .prof_i(prof),
    .rate_en_o(osc_rate_en_o), .en2_o(osc_en2_o)
  );

  assign en16_o    = en[EN_16];
  assign en8_o     = en[EN_8];
  assign en4_o     = en[EN_4];
  assign en2_o     = en[EN_2];
  assign en500k_o  = en[EN_500K];
  assign bus_en_o  = en[EN_BUS];
  assign cpu_en_o  = en[EN_CPU];
  assign blit_en_o = en[EN_BLIT];
endmodule

// File: tb/sim_clken_tree.sv
`timescale 1ns/100ps
module sim_clken_tree;
  logic clk = 1'b0, osc_clk = 1'b0, rst_n = 1'b0, srst = 1'b0;
  logic [2:0] profile = 3'd0;
  logic en16, en8, en4, en2, en500k, bus_en, cpu_en, blit_en, osc_rate, osc_en2;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  always #3.5 osc_clk = ~osc_clk;

  clken_tree u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_clk_i(osc_clk), .srst_i(srst),
    .profile_i(profile), .en16_o(en16), .en8_o(en8), .en4_o(en4),
    .en2_o(en2), .en500k_o(en500k), .bus_en_o(bus_en), .cpu_en_o(cpu_en),
    .blit_en_o(blit_en), .osc_rate_en_o(osc_rate), .osc_en2_o(osc_en2)
  );

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // expected period in master cycles, 0 = never
  function automatic int exp_per(int p, int idx);
    int per [5][8] = '{
      '{2, 4, 8, 16, 64, 4, 4, 4},
      '{2, 4, 8,  0, 64, 4, 4, 4},
      '{2, 4, 8,  0, 64, 4, 2, 4},
      '{2, 4, 8, 16, 64, 2, 1, 0},
      '{2, 4, 8, 16, 64, 2, 2, 2}};
    return per[p][idx];
  endfunction

  function automatic string idx_tag(int idx);
    case (idx)
      3:       return "R4";
      4:       return "R5";
      5:       return "R6";
      6:       return "R7";
      7:       return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic soft_reset(logic [2:0] code);
    @(negedge clk);
    profile = code;
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
  endtask

  task automatic count_master(string pre, int p);
    int cnt [8];
    int mis = 0;
    foreach (cnt[i]) cnt[i] = 0;
    for (int c = 0; c < 1024; c++) begin
      @(negedge clk);
      if (en16) cnt[0]++;
      if (en8) cnt[1]++;
      if (en4) cnt[2]++;
      if (en2) cnt[3]++;
      if (en500k) cnt[4]++;
      if (bus_en) cnt[5]++;
      if (cpu_en) cnt[6]++;
      if (blit_en) cnt[7]++;
      if (en500k && !(en16 && en8 && en4)) mis++;
    end
    for (int i = 0; i < 8; i++) begin
      int per = exp_per(p, i);
      check($sformatf("%s %s out%0d", pre, idx_tag(i), i), cnt[i],
            per == 0 ? 0 : 1024 / per);
    end
    check($sformatf("%s R12 align", pre), mis, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    profile = 3'd3;
    repeat (4) @(negedge clk);
    check("R1 reset outs",
          {en16, en8, en4, en2, en500k, bus_en, cpu_en, blit_en, osc_rate, osc_en2}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    count_master("R1 post-reset", 0);
  endtask

  task automatic t_profile(logic [2:0] code);
    int p = (code > 3'd4) ? 0 : int'(code);
    string pre = (code > 3'd4) ? $sformatf("R10 code%0d", code) : $sformatf("prof%0d", code);
    int rate_c = 0, en2_c = 0;
    soft_reset(code);
    repeat (4) @(negedge clk);
    count_master(pre, p);
    repeat (8) @(negedge osc_clk);
    for (int c = 0; c < 1024; c++) begin
      @(negedge osc_clk);
      if (osc_rate) rate_c++;
      if (osc_en2) en2_c++;
    end
    check($sformatf("%s R9 osc rate", pre), rate_c, p == 1 ? 1024 : p == 2 ? 512 : 0);
    check($sformatf("%s R9 osc en2", pre), en2_c, p == 1 ? 256 : p == 2 ? 128 : 0);
  endtask

  task automatic t_ignore();
    int c_cpu = 0, c_en2 = 0, c_blit = 0;
    soft_reset(3'd3);
    @(negedge clk);
    profile = 3'd1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 1024; c++) begin
      @(negedge clk);
      if (cpu_en) c_cpu++;
      if (en2) c_en2++;
      if (blit_en) c_blit++;
    end
    check("R2 cpu keeps profile 3", c_cpu, 1024);
    check("R2 en2 keeps profile 3", c_en2, 64);
    check("R2 blit keeps profile 3", c_blit, 0);
  endtask

  task automatic t_collide();
    int guard = 0, f16 = 0, f8 = 0, f500 = 0;
    soft_reset(3'd0);
    while (!en500k && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check("R11 found 500k", guard < 200, 1);
    repeat (63) @(negedge clk);
    srst = 1'b1;
    @(negedge clk);
    srst = 1'b0;
    check("R11 srst overrides due 500k", en500k, 0);
    check("R11 srst clears 16", en16, 0);
    for (int k = 1; k <= 64; k++) begin
      @(negedge clk);
      if (en16 && f16 == 0) f16 = k;
      if (en8 && f8 == 0) f8 = k;
      if (en500k && f500 == 0) f500 = k;
    end
    check("R11 first en16", f16, 1);
    check("R11 first en8", f8, 3);
    check("R11 first en500k", f500, 63);
  endtask

  initial begin
    t_reset();
    for (int c = 0; c < 8; c++) t_profile(3'(c));
    t_ignore();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule